// File: doc/BRIEF.md
# Receive Frame Statistics Collector

This block counts receive-side frame completions for one Ethernet port. Every completion event gives the frame length in bytes, including the 4-byte FCS, and a flag that says whether the FCS checked good. From these events the block keeps a set of 64-bit counters:

- total packets and total bytes;
- good packets and good bytes;
- frames above a programmable length limit, held in two counters (oversize and too-long);
- a free-running cycle count, which gives a time base for rates;
- a fourteen-way length histogram, with bins that cover VLAN-tagged and jumbo sizes.

Software freezes a coherent view with a snapshot strobe. The strobe copies every live counter into a shadow bank in one cycle. It can also restart the live counters in that same cycle. Reads always come from the shadow bank, so the low and high words of any counter come from the same instant.

The length limit sits in a 15-bit field of a configuration word. It resets to 9600. A frame longer than the limit still counts in the totals and in its histogram bin, but it is kept out of the good counts. Frame lengths up to 32767 bytes are counted exactly.

Top module: `fstat_rx_stats`

## Requirements
- R1: After reset every shadow counter reads zero, and the configuration word at byte address 0x000 reads 0x25800000: the limit is 9600, in bits 30:16, and all other bits are zero.
- R2: Each event adds one to total packets (counter 0) and adds its length to total bytes (counter 2). This holds whatever the FCS flag and the limit are.
- R3: An event adds one to good packets (counter 1) and adds its length to good bytes (counter 3) only when its FCS flag is 1 and its length is not above the limit.
- R4: An event whose length is above the limit adds one to both oversize (counter 4) and too-long (counter 5), whatever its FCS flag.
- R5: Each event adds one to exactly one histogram counter. Counters 7 to 20 hold, in order: below 64; exactly 64; 65-127; 128-255; 256-511; 512-1023; 1024-1518; 1519-1522; 1523-1548; 1549-2047; 2048-4095; 4096-8191; 8192-9215; above 9215.
- R6: Byte counters are 64 bits wide and stay exact for frames up to 32767 bytes, including frames at or above 16384.
- R7: A write of the configuration word loads bits 30:16 as the new limit and ignores all other bits. Events in later cycles are judged against the new value.
- R8: Counter 6 adds one on every clock cycle after reset.
- R9: A snapshot strobe copies every live counter into the shadow bank. The copy holds the values from before that cycle's event. When no snapshot is taken, the shadow bank does not change.
- R10: When the clear bit is set together with the snapshot strobe, the live counters restart from zero in that cycle. An event in that same cycle counts in the new interval only.
- R11: Counter k has its low word at byte address 0x100+8k and its high word at 0x104+8k. Read data and the hit flag appear in the cycle after the read strobe. An address that maps to no counter and is not the configuration word returns 0 with the hit flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Frame completion event strobe |
| ev_len | input | 15 | Frame length in bytes, FCS included |
| ev_fcs_ok | input | 1 | FCS of the frame was good |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word; limit in bits 30:16 |
| snap | input | 1 | Snapshot strobe |
| snap_clear | input | 1 | Restart live counters with this snapshot |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_hit | output | 1 | Address mapped to a register |
| rd_data | output | 32 | Read data |

## Verification
Two functions can act in the same cycle. A snapshot with clear can meet a frame event, and a limit write can be followed at once by a frame whose length lies between the old limit and the new one. The bench drives the strobe and the event on the same clock edge. It then takes a second snapshot and checks two things: the first shadow copy excludes that frame, and the restarted interval contains it exactly once. The limit case is judged by the move of a frame between the good counts and the oversize counts.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  localparam int LEN_W_D    = 15;
  localparam int DATA_W_D   = 32;
  localparam int NUM_BINS_D = 14;

  // live counter slots
  localparam int IX_TOT_PKT   = 0;
  localparam int IX_GOOD_PKT  = 1;
  localparam int IX_TOT_BYTE  = 2;
  localparam int IX_GOOD_BYTE = 3;
  localparam int IX_OVERSIZE  = 4;
  localparam int IX_TOOLONG   = 5;
  localparam int IX_CYCLE     = 6;
  localparam int IX_BIN0      = 7;
  localparam int NUM_CNT_D    = IX_BIN0 + NUM_BINS_D;

  localparam int THR_RESET = 9600;
  localparam int THR_LSB   = 16;

  // histogram slot for a frame length; upper edges are inclusive
  function automatic int fstat_bin(input int unsigned len);
    if (len < 64)         return 0;
    else if (len == 64)   return 1;
    else if (len <= 127)  return 2;
    else if (len <= 255)  return 3;
    else if (len <= 511)  return 4;
    else if (len <= 1023) return 5;
    else if (len <= 1518) return 6;
    else if (len <= 1522) return 7;
    else if (len <= 1548) return 8;
    else if (len <= 2047) return 9;
    else if (len <= 4095) return 10;
    else if (len <= 8191) return 11;
    else if (len <= 9215) return 12;
    else                  return 13;
  endfunction

  // good frame: FCS fine and length within the limit
  function automatic logic fstat_is_good(input int unsigned len,
                                         input int unsigned limit,
                                         input logic fcs_ok);
    return fcs_ok && (len <= limit);
  endfunction
endpackage

// File: rtl/fstat_classify.sv
module fstat_classify
  import fstat_pkg::*;
#(
  parameter int LEN_W    = LEN_W_D,
  parameter int NUM_BINS = NUM_BINS_D
) (
  input  logic                ev_valid,
  input  logic [LEN_W-1:0]    ev_len,
  input  logic                ev_fcs_ok,
  input  logic [LEN_W-1:0]    limit,
  output logic                ev_good,
  output logic                ev_over,
  output logic [NUM_BINS-1:0] bin_oh
);
  localparam int BIN_W = $clog2(NUM_BINS);

  logic [BIN_W-1:0] bin_idx;

  always_comb begin
    bin_idx = BIN_W'(fstat_bin(32'(ev_len)));
    ev_over = ev_valid && (ev_len > limit);
    ev_good = ev_valid && fstat_is_good(32'(ev_len), 32'(limit), ev_fcs_ok);
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    assign bin_oh[b] = ev_valid && (bin_idx == BIN_W'(b));
  end
endmodule

// File: rtl/fstat_counter_bank.sv
module fstat_counter_bank
  import fstat_pkg::*;
#(
  parameter int CNT_W   = 2 * DATA_W_D,
  parameter int NUM_CNT = NUM_CNT_D,
  parameter int INC_W   = LEN_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc [NUM_CNT],
  input  logic             snap,
  input  logic             snap_clear,
  output logic [CNT_W-1:0] shadow [NUM_CNT]
);
  logic [CNT_W-1:0] live [NUM_CNT];
  logic             restart;

  assign restart = snap && snap_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_CNT; k++) begin
        live[k]   <= '0;
        shadow[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NUM_CNT; k++) begin
        if (snap) shadow[k] <= live[k];
        if (restart) live[k] <= CNT_W'(inc[k]);
        else         live[k] <= live[k] + CNT_W'(inc[k]);
      end
    end
  end

  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> (shadow[IX_TOT_PKT] == $past(shadow[IX_TOT_PKT]) &&
               shadow[IX_TOT_BYTE] == $past(shadow[IX_TOT_BYTE]) &&
               shadow[IX_CYCLE] == $past(shadow[IX_CYCLE])));

  p_good_pkt_le_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live[IX_GOOD_PKT] <= live[IX_TOT_PKT]);

  p_good_byte_le_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live[IX_GOOD_BYTE] <= live[IX_TOT_BYTE]);

  p_cycle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> live[IX_CYCLE] == $past(live[IX_CYCLE]) + 1);

  p_restart_small_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> live[IX_TOT_PKT] <= 1);
endmodule

// File: rtl/fstat_readout.sv
module fstat_readout
  import fstat_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = DATA_W_D,
  parameter int NUM_CNT = NUM_CNT_D,
  parameter int BASE    = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [2*DATA_W-1:0] shadow [NUM_CNT],
  input  logic [DATA_W-1:0] cfg_word,
  output logic              rd_valid,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE + 8 * NUM_CNT);

  logic [ADDR_W-1:0] off;
  logic              hit_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    off    = rd_addr - BASE_A;
    hit_d  = 1'b0;
    data_d = '0;
    if (rd_addr == '0) begin
      hit_d  = 1'b1;
      data_d = cfg_word;
    end else if (rd_addr >= BASE_A && rd_addr < END_A && rd_addr[1:0] == 2'b00) begin
      for (int k = 0; k < NUM_CNT; k++) begin
        if (off[ADDR_W-1:3] == (ADDR_W-3)'(k)) begin
          hit_d  = 1'b1;
          data_d = off[2] ? shadow[k][2*DATA_W-1:DATA_W] : shadow[k][DATA_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_hit   <= rd_en && hit_d;
      rd_data  <= rd_en ? data_d : '0;
    end
  end

  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_hit) |-> rd_data == '0);
endmodule

// File: rtl/fstat_rx_stats.sv
module fstat_rx_stats
  import fstat_pkg::*;
#(
  parameter int LEN_W    = LEN_W_D,
  parameter int DATA_W   = DATA_W_D,
  parameter int ADDR_W   = 12,
  parameter int NUM_BINS = NUM_BINS_D,
  parameter int BASE     = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_fcs_ok,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              snap,
  input  logic              snap_clear,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NUM_CNT = IX_BIN0 + NUM_BINS;
  localparam int CNT_W   = 2 * DATA_W;

  logic [LEN_W-1:0]    limit;
  logic [DATA_W-1:0]   cfg_word;
  logic                ev_good;
  logic                ev_over;
  logic [NUM_BINS-1:0] bin_oh;
  logic [LEN_W-1:0]    inc [NUM_CNT];
  logic [CNT_W-1:0]    shadow [NUM_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      limit <= LEN_W'(THR_RESET);
    else if (cfg_we) limit <= cfg_wdata[THR_LSB +: LEN_W];
  end

  assign cfg_word = DATA_W'(limit) << THR_LSB;

  fstat_classify #(.LEN_W(LEN_W), .NUM_BINS(NUM_BINS)) i_classify (
    .ev_valid (ev_valid),
    .ev_len   (ev_len),
    .ev_fcs_ok(ev_fcs_ok),
    .limit    (limit),
    .ev_good  (ev_good),
    .ev_over  (ev_over),
    .bin_oh   (bin_oh)
  );

  assign inc[IX_TOT_PKT]   = LEN_W'(ev_valid);
  assign inc[IX_GOOD_PKT]  = LEN_W'(ev_good);
  assign inc[IX_TOT_BYTE]  = ev_valid ? ev_len : '0;
  assign inc[IX_GOOD_BYTE] = ev_good ? ev_len : '0;
  assign inc[IX_OVERSIZE]  = LEN_W'(ev_over);
  assign inc[IX_TOOLONG]   = LEN_W'(ev_over);
  assign inc[IX_CYCLE]     = LEN_W'(1);

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_hist
    assign inc[IX_BIN0 + b] = LEN_W'(bin_oh[b]);
  end

  fstat_counter_bank #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .INC_W(LEN_W)) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (inc),
    .snap      (snap),
    .snap_clear(snap_clear),
    .shadow    (shadow)
  );

  fstat_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CNT(NUM_CNT), .BASE(BASE)) i_readout (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .shadow  (shadow),
    .cfg_word(cfg_word),
    .rd_valid(rd_valid),
    .rd_hit  (rd_hit),
    .rd_data (rd_data)
  );

  p_limit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(limit));

  p_bin_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $countones(bin_oh) == 1);

  p_over_not_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_over |-> !ev_good);
endmodule

// File: tb/test_fstat_rx_stats.sv
module test_fstat_rx_stats;
  localparam int CLK_P = 10;
  localparam int NC    = 21;
  localparam int C_TP = 0, C_GP = 1, C_TB = 2, C_GB = 3, C_OV = 4, C_TL = 5, C_CY = 6, C_H0 = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [14:0] ev_len = '0;
  logic        ev_fcs_ok = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        snap = 1'b0;
  logic        snap_clear = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic        rd_valid;
  logic        rd_hit;
  logic [31:0] rd_data;

  int tests = 0;
  int fails = 0;
  longint unsigned tb_cyc = 0;
  longint unsigned cyc_base = 0;
  logic [63:0] exp_live [NC];
  logic [63:0] exp_sh [NC];
  int unsigned exp_thr = 9600;

  logic [32:0] q_exp [$];
  string       q_tag [$];

  always #(CLK_P/2) clk = ~clk;

  fstat_rx_stats i_fstat_rx_stats (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_len(ev_len), .ev_fcs_ok(ev_fcs_ok),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .snap(snap), .snap_clear(snap_clear),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_data(rd_data)
  );

  always @(posedge clk) if (rst_n) tb_cyc = tb_cyc + 1;

  // histogram slot from a table of inclusive upper edges
  function automatic int hist_slot(input int unsigned len);
    int unsigned edges [13] = '{63, 64, 127, 255, 511, 1023, 1518, 1522, 1548, 2047, 4095, 8191, 9215};
    for (int i = 0; i < 13; i++) if (len <= edges[i]) return i;
    return 13;
  endfunction

  // monitor: compares read responses against the queue
  always @(negedge clk) begin
    if (rd_valid) begin
      logic [32:0] e;
      string t;
      tests++;
      if (q_exp.size() == 0) begin
        fails++;
        $display("FAIL unexpected read response: got hit=%0b data=%h expected none", rd_hit, rd_data);
      end else begin
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if ({rd_hit, rd_data} !== e)
          $display("FAIL %s: got hit=%0b data=%h expected hit=%0b data=%h",
                   t, rd_hit, rd_data, e[32], e[31:0]);
        if ({rd_hit, rd_data} !== e) fails++;
      end
    end
  end

  task automatic model_event(input int unsigned len, input logic ok);
    exp_live[C_TP] += 1;
    exp_live[C_TB] += 64'(len);
    if (len > exp_thr) begin
      exp_live[C_OV] += 1;
      exp_live[C_TL] += 1;
    end else if (ok) begin
      exp_live[C_GP] += 1;
      exp_live[C_GB] += 64'(len);
    end
    exp_live[C_H0 + hist_slot(len)] += 1;
  endtask

  task automatic model_snap(input logic clr);
    for (int k = 0; k < NC; k++) if (k != C_CY) exp_sh[k] = exp_live[k];
    exp_sh[C_CY] = tb_cyc - cyc_base;
    if (clr) begin
      for (int k = 0; k < NC; k++) exp_live[k] = '0;
      cyc_base = tb_cyc;
    end
  endtask

  // all drivers start and end on a falling edge
  task automatic send(input int unsigned len, input logic ok);
    ev_valid = 1'b1; ev_len = 15'(len); ev_fcs_ok = ok;
    model_event(len, ok);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic take_snap(input logic clr);
    snap = 1'b1; snap_clear = clr;
    model_snap(clr);
    @(negedge clk);
    snap = 1'b0; snap_clear = 1'b0;
  endtask

  task automatic snap_with_event(input int unsigned len, input logic ok);
    snap = 1'b1; snap_clear = 1'b1;
    ev_valid = 1'b1; ev_len = 15'(len); ev_fcs_ok = ok;
    model_snap(1'b1);
    model_event(len, ok);
    @(negedge clk);
    snap = 1'b0; snap_clear = 1'b0; ev_valid = 1'b0;
  endtask

  task automatic write_cfg(input logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    exp_thr = int'(w[30:16]);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic h, input logic [31:0] d, input string tag);
    rd_en = 1'b1; rd_addr = a;
    q_exp.push_back({h, d});
    q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic dump(input string tag);
    do_read(12'h000, 1'b1, {1'b0, 15'(exp_thr), 16'h0}, {tag, " cfg R7"});
    for (int k = 0; k < NC; k++) begin
      do_read(12'(12'h100 + 8 * k), 1'b1, exp_sh[k][31:0], $sformatf("%s cnt%0d lo", tag, k));
      do_read(12'(12'h104 + 8 * k), 1'b1, exp_sh[k][63:32], $sformatf("%s cnt%0d hi", tag, k));
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) begin exp_live[k] = '0; exp_sh[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values, read without any snapshot
    dump("R1 reset");

    // R2 R3 R4 R5 R8 R9: histogram edges, bad FCS, limit edges
    send(63, 1'b1);   send(64, 1'b1);   send(65, 1'b1);   send(127, 1'b1);
    send(128, 1'b1);  send(255, 1'b1);  send(256, 1'b1);  send(511, 1'b1);
    send(512, 1'b1);  send(1023, 1'b1); send(1024, 1'b1); send(1518, 1'b1);
    send(1519, 1'b1); send(1522, 1'b1); send(1523, 1'b1); send(1548, 1'b1);
    send(1549, 1'b1); send(2047, 1'b1); send(2048, 1'b1); send(4095, 1'b1);
    send(4096, 1'b1); send(8191, 1'b1); send(8192, 1'b1); send(9215, 1'b1);
    send(9216, 1'b1); send(9600, 1'b1); send(9601, 1'b1); send(9601, 1'b0);
    send(100, 1'b0);  send(40, 1'b1);
    repeat (4) @(negedge clk);
    take_snap(1'b0);
    dump("R2 R3 R4 R5 R8 R9 mix");

    // R9: events without a snapshot leave the shadow untouched
    send(500, 1'b1); send(700, 1'b0);
    dump("R9 hold");

    // R7: limit write, other bits ignored; frame between old and new limit
    write_cfg({1'b1, 15'd16383, 16'hABCD});
    send(9700, 1'b1);
    // R6: long frames counted exactly
    send(16383, 1'b1); send(16384, 1'b1);
    send(32767, 1'b1); send(32767, 1'b1); send(32767, 1'b0);
    write_cfg({1'b0, 15'd32767, 16'h0000});
    send(32767, 1'b1); send(16384, 1'b1);
    take_snap(1'b0);
    dump("R6 R7 long");

    // R10: clear with a same-cycle event, then view the new interval
    send(300, 1'b1);
    snap_with_event(1600, 1'b1);
    dump("R10 old interval");
    send(64, 1'b0);
    repeat (5) @(negedge clk);
    take_snap(1'b0);
    dump("R10 new interval");

    // R11: unmapped addresses
    do_read(12'h0F0, 1'b0, 32'h0, "R11 gap below counters");
    do_read(12'h1A8, 1'b0, 32'h0, "R11 past last counter");
    do_read(12'h102, 1'b0, 32'h0, "R11 misaligned");
    do_read(12'h004, 1'b0, 32'h0, "R11 next to cfg");
    do_read(12'hFFC, 1'b0, 32'h0, "R11 top of window");
    repeat (3) @(negedge clk);

    if (q_exp.size() != 0) begin
      tests++; fails++;
      $display("FAIL R11 missing read responses: got %0d pending expected 0", q_exp.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule